// File: doc/BRIEF.md
# Fixed-Slot SDRAM Command Sequencer

This block drives a single 16-bit SDRAM from a repeating 16-state time slot clocked at twice the pixel rate. Each slot carries exactly one of four operations: a 32-bit display fetch closed by an auto-refresh, a processor read, a processor write, or an idle pass in which the memory is left with its clock disabled. The operation is chosen once per slot, at a single decision state, from a display/processor select supplied by the client together with a 68000-style address strobe that is qualified by a RAM/ROM select, and a read/write line.

Every operation finishes within its slot, so the surrounding logic can time its bus acknowledge from the slot phase alone; the block offers no ready signal. Between operations the clock-enable pin is held low, which freezes the memory, and inside a display slot it is pulsed so that the two returned halves stay on the data pins long enough to be captured at relaxed points. The block also drives the output enable and direction of an external data-bus transceiver that joins the processor bus to the shared SDRAM data lines.

Top module: `sdram_slot_seq`

## Requirements
- R1: After reset `slot_phase` is 0; it then advances by one on every clock and wraps from 15 to 0.
- R2: Command codes on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} are NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, REFRESH 0001. In phases 0-3 and 13-15 the command is NOP with sd_cke low; in phase 4 it is NOP with sd_cke high, in every slot.
- R3: In phase 5 sd_cke is high and the choice is made from the live inputs: ACTIVATE when vid_sel is 1, or when vid_sel is 0 and the qualified strobe is active (cpu_as_n 0 and cpu_ram_sel 1); NOP otherwise. The choice is latched at the end of phase 5 and holds for the rest of the slot.
- R4: Display slot: READ in phase 6 at the even column, READ with auto-precharge in phase 7 at the odd column, REFRESH in phase 11, NOP elsewhere; sd_cke is high in phases 6, 7, 9, 11, 12 and low in 8 and 10.
- R5: In a display slot sd_dq_in is captured at the end of phase 9 and at the end of phase 11; vid_word becomes {value at end of phase 11, value at end of phase 9} from phase 12 and holds until the next display capture. Non-display slots leave vid_word unchanged.
- R6: Processor read slot: READ with auto-precharge in phase 7, NOP elsewhere, sd_cke high in phases 6-12; xcvr_to_cpu is 1 in phases 7-14 and xcvr_oe_n is 0 in phases 9-14.
- R7: Processor write slot: WRITE with auto-precharge in phase 7 with sd_dqm equal to cpu_be_n (bit 1 upper byte; a lane whose strobe is inactive is masked); sd_cke high in phases 6-12; xcvr_oe_n 0 in phases 6-8 and xcvr_to_cpu 0. sd_dqm is 0 in every other phase and slot.
- R8: Idle slot: after phase 5 only NOP with sd_cke low is issued and the transceiver stays disabled, even if the strobe becomes active later in the slot; an I/O access (cpu_ram_sel 0) gives an idle slot.
- R9: Word addresses split as column [8:0], row [20:9], bank [22:21] and are sampled in phase 5 from vid_waddr in a display slot or cpu_waddr otherwise. ACTIVATE drives the row on sd_addr and the bank on sd_ba; READ/WRITE drive the column on sd_addr[8:0], the auto-precharge flag on sd_addr[10] and zero elsewhere, with the bank again on sd_ba. Outside those commands sd_addr and sd_ba are 0.
- R10: xcvr_oe_n is 1 throughout display and idle slots and in phases 0-5 and 15; xcvr_to_cpu is 0 outside the read window of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twice the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_phase | output | 4 | Current phase of the 16-state slot |
| vid_sel | input | 1 | 1 requests a display fetch in this slot |
| vid_waddr | input | 23 | Display word address (bit 0 ignored) |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_ram_sel | input | 1 | 1 when the processor address decodes to RAM/ROM |
| cpu_rd_wr_n | input | 1 | 1 read, 0 write |
| cpu_be_n | input | 2 | Byte strobes, active low, bit 1 upper |
| cpu_waddr | input | 23 | Processor word address (A23..A1) |
| sd_dq_in | input | 16 | SDRAM read data |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_ba | output | 2 | SDRAM bank select |
| sd_addr | output | 12 | SDRAM row/column address |
| sd_dqm | output | 2 | SDRAM byte masks, 1 masks a lane |
| vid_word | output | 32 | Last fetched 32-bit display word |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 drives the processor bus |

## Verification
The assertions assume the client keeps vid_sel and vid_waddr steady from phase 5 through phase 14, and that a processor whose strobe is sampled active in phase 5 keeps cpu_as_n, cpu_rd_wr_n, cpu_be_n and cpu_waddr unchanged until the slot ends. The stimulus changes these inputs only at the falling edge that ends phase 15, with one exception: in a slot decided idle it drops the strobe in mid-slot on purpose, which the contract allows, to show no partial access follows. Read data on sd_dq_in changes every cycle at falling edges so each capture point sees a distinct value.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

   localparam int PH_W = 4;

   typedef logic [PH_W-1:0] phase_t;
   typedef logic [3:0]      sd_cmd_t;

   typedef enum logic [1:0] {
      SLOT_IDLE = 2'd0,
      SLOT_VID  = 2'd1,
      SLOT_RD   = 2'd2,
      SLOT_WR   = 2'd3
   } slot_kind_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam sd_cmd_t CMD_NOP   = 4'b0111;
   localparam sd_cmd_t CMD_ACT   = 4'b0011;
   localparam sd_cmd_t CMD_READ  = 4'b0101;
   localparam sd_cmd_t CMD_WRITE = 4'b0100;
   localparam sd_cmd_t CMD_REF   = 4'b0001;

   // slot schedule
   localparam phase_t PH_WAKE     = 4'd4;
   localparam phase_t PH_DECIDE   = 4'd5;
   localparam phase_t PH_COL0     = 4'd6;
   localparam phase_t PH_COL1     = 4'd7;
   localparam phase_t PH_GAP0     = 4'd8;
   localparam phase_t PH_CAP0     = 4'd9;
   localparam phase_t PH_GAP1     = 4'd10;
   localparam phase_t PH_CAP1     = 4'd11;
   localparam phase_t PH_CKE_LAST = 4'd12;
   localparam phase_t PH_XC_LAST  = 4'd14;
   localparam phase_t PH_RDOE_1ST = 4'd9;
   localparam phase_t PH_WROE_END = 4'd8;

endpackage

// File: rtl/sdseq_phase_ctr.sv
module sdseq_phase_ctr
   import sdseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_t phase
);

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + 1'b1;
   end

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase == PH_W'($past(phase) + 1'b1)); // R1

endmodule

// File: rtl/sdseq_slot_decide.sv
module sdseq_slot_decide
   import sdseq_pkg::*;
#(
   parameter int WA_W = 23
)(
   input  logic            clk,
   input  logic            rst_n,
   input  phase_t          phase,
   input  logic            vid_sel,
   input  logic [WA_W-1:0] vid_waddr,
   input  logic            cpu_as_n,
   input  logic            cpu_ram_sel,
   input  logic            cpu_rd_wr_n,
   input  logic [WA_W-1:0] cpu_waddr,
   output slot_kind_t      kind_now,
   output slot_kind_t      kind_q,
   output logic [WA_W-1:0] waddr_now,
   output logic [WA_W-1:0] waddr_q
);

   logic strobe_ok;

   assign strobe_ok = !cpu_as_n && cpu_ram_sel;

   always_comb begin
      if (vid_sel)         kind_now = SLOT_VID;
      else if (!strobe_ok) kind_now = SLOT_IDLE;
      else if (cpu_rd_wr_n) kind_now = SLOT_RD;
      else                 kind_now = SLOT_WR;
   end

   assign waddr_now = vid_sel ? vid_waddr : cpu_waddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= SLOT_IDLE;
         waddr_q <= '0;
      end else if (phase == PH_DECIDE) begin
         kind_q  <= kind_now;
         waddr_q <= waddr_now;
      end
   end

   AST_IO_NEVER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DECIDE && !vid_sel && !cpu_ram_sel) |=> kind_q == SLOT_IDLE); // R8

   AST_LATE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_DECIDE) |=> $stable(kind_q)); // R3

endmodule

// File: rtl/sdseq_cmd_gen.sv
module sdseq_cmd_gen
   import sdseq_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter int ROW_W  = 12,
   parameter int BANK_W = 2,
   parameter int SA_W   = 12,
   parameter int AP_BIT = 10,
   parameter int BYTES  = 2,
   localparam int WA_W  = COL_W + ROW_W + BANK_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase,
   input  slot_kind_t        kind_now,
   input  slot_kind_t        kind_q,
   input  logic [WA_W-1:0]   waddr_now,
   input  logic [WA_W-1:0]   waddr_q,
   input  logic [BYTES-1:0]  cpu_be_n,
   output sd_cmd_t           cmd,
   output logic              cke,
   output logic [BANK_W-1:0] ba,
   output logic [SA_W-1:0]   sa,
   output logic [BYTES-1:0]  dqm,
   output logic              oe_n,
   output logic              to_cpu
);

   logic [COL_W-1:0]  col_q;
   logic [ROW_W-1:0]  row_now;
   logic [BANK_W-1:0] bank_now, bank_q;
   logic              in_body, in_cke_body, wr_mask_phase;

   assign col_q    = waddr_q[COL_W-1:0];
   assign row_now  = waddr_now[COL_W +: ROW_W];
   assign bank_now = waddr_now[COL_W+ROW_W +: BANK_W];
   assign bank_q   = waddr_q[COL_W+ROW_W +: BANK_W];

   assign in_body     = (phase >= PH_COL0) && (phase <= PH_XC_LAST);
   assign in_cke_body = (phase >= PH_COL0) && (phase <= PH_CKE_LAST);

   function automatic logic [SA_W-1:0] col_addr(input logic [COL_W-1:0] c, input logic ap);
      logic [SA_W-1:0] r;
      r = '0;
      r[COL_W-1:0] = c;
      r[AP_BIT]    = ap;
      return r;
   endfunction

   always_comb begin
      cmd    = CMD_NOP;
      cke    = 1'b0;
      ba     = '0;
      sa     = '0;
      oe_n   = 1'b1;
      to_cpu = 1'b0;
      if (phase == PH_WAKE) begin
         cke = 1'b1;
      end else if (phase == PH_DECIDE) begin
         cke = 1'b1;
         if (kind_now != SLOT_IDLE) begin
            cmd = CMD_ACT;
            ba  = bank_now;
            sa  = SA_W'(row_now);
         end
      end else if (in_body) begin
         unique case (kind_q)
            SLOT_VID: begin
               cke = in_cke_body && (phase != PH_GAP0) && (phase != PH_GAP1);
               if (phase == PH_COL0) begin
                  cmd = CMD_READ;
                  ba  = bank_q;
                  sa  = col_addr({col_q[COL_W-1:1], 1'b0}, 1'b0);
               end else if (phase == PH_COL1) begin
                  cmd = CMD_READ;
                  ba  = bank_q;
                  sa  = col_addr({col_q[COL_W-1:1], 1'b1}, 1'b1);
               end else if (phase == PH_CAP1) begin
                  cmd = CMD_REF;
               end
            end
            SLOT_RD: begin
               cke    = in_cke_body;
               to_cpu = (phase >= PH_COL1);
               oe_n   = !(phase >= PH_RDOE_1ST);
               if (phase == PH_COL1) begin
                  cmd = CMD_READ;
                  ba  = bank_q;
                  sa  = col_addr(col_q, 1'b1);
               end
            end
            SLOT_WR: begin
               cke  = in_cke_body;
               oe_n = !(phase <= PH_WROE_END);
               if (phase == PH_COL1) begin
                  cmd = CMD_WRITE;
                  ba  = bank_q;
                  sa  = col_addr(col_q, 1'b1);
               end
            end
            default: begin
               cke = 1'b0;
            end
         endcase
      end
   end

   assign wr_mask_phase = (kind_q == SLOT_WR) && (phase == PH_COL1);

   generate
      for (genvar gi = 0; gi < BYTES; gi++) begin : g_mask
         assign dqm[gi] = wr_mask_phase & cpu_be_n[gi];
      end
   endgenerate

   AST_QUIET_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (phase < PH_WAKE || phase > PH_CKE_LAST) |-> (!cke && cmd == CMD_NOP)); // R2
   AST_ACT_ONLY_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> (phase == PH_DECIDE)); // R3
   AST_REF_IN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REF) |-> (kind_q == SLOT_VID && phase == PH_CAP1)); // R4
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == SLOT_IDLE && phase > PH_DECIDE) |-> (cmd == CMD_NOP && !cke && oe_n)); // R8
   AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (dqm != '0) |-> (cmd == CMD_WRITE)); // R7
   AST_VIDEO_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == SLOT_VID && phase > PH_DECIDE) |-> oe_n); // R10

endmodule

// File: rtl/sdseq_vid_capture.sv
module sdseq_vid_capture
   import sdseq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int WORDS  = 2,
   localparam int VW    = DATA_W * WORDS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase,
   input  slot_kind_t        kind_q,
   input  logic [DATA_W-1:0] dq_in,
   output logic [VW-1:0]     vid_word
);

   logic take;
   logic [VW-1:0] shifted;

   assign take = (kind_q == SLOT_VID) && ((phase == PH_CAP0) || (phase == PH_CAP1));

   generate
      for (genvar gw = 0; gw < WORDS; gw++) begin : g_lane
         if (gw == WORDS - 1) begin : g_top
            assign shifted[gw*DATA_W +: DATA_W] = dq_in;
         end else begin : g_mid
            assign shifted[gw*DATA_W +: DATA_W] = vid_word[(gw+1)*DATA_W +: DATA_W];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    vid_word <= '0;
      else if (take) vid_word <= shifted;
   end

   AST_VWORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(kind_q == SLOT_VID && (phase == PH_CAP0 || phase == PH_CAP1)) |=> $stable(vid_word)); // R5
   AST_VWORD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == SLOT_VID && phase == PH_CAP1) |=> vid_word[VW-1 -: DATA_W] == $past(dq_in)); // R5

endmodule

// File: rtl/sdram_slot_seq.sv
module sdram_slot_seq
   import sdseq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COL_W  = 9,
   parameter int ROW_W  = 12,
   parameter int BANK_W = 2,
   parameter int SA_W   = 12,
   parameter int AP_BIT = 10,
   localparam int BYTES = DATA_W / 8,
   localparam int WA_W  = COL_W + ROW_W + BANK_W,
   localparam int VW    = 2 * DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [3:0]        slot_phase,
   input  logic              vid_sel,
   input  logic [WA_W-1:0]   vid_waddr,
   input  logic              cpu_as_n,
   input  logic              cpu_ram_sel,
   input  logic              cpu_rd_wr_n,
   input  logic [BYTES-1:0]  cpu_be_n,
   input  logic [WA_W-1:0]   cpu_waddr,
   input  logic [DATA_W-1:0] sd_dq_in,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic              sd_cke,
   output logic [BANK_W-1:0] sd_ba,
   output logic [SA_W-1:0]   sd_addr,
   output logic [BYTES-1:0]  sd_dqm,
   output logic [VW-1:0]     vid_word,
   output logic              xcvr_oe_n,
   output logic              xcvr_to_cpu
);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (AP_BIT >= SA_W || COL_W > AP_BIT) begin : g_bad_ap
         $error("auto-precharge bit must sit above the column and inside sd_addr");
      end
      if (ROW_W > SA_W) begin : g_bad_row
         $error("row does not fit on sd_addr");
      end
   endgenerate

   phase_t     phase;
   slot_kind_t kind_now, kind_q;
   logic [WA_W-1:0] waddr_now, waddr_q;
   sd_cmd_t    cmd;

   sdseq_phase_ctr i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   sdseq_slot_decide #(.WA_W(WA_W)) i_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .vid_sel     (vid_sel),
      .vid_waddr   (vid_waddr),
      .cpu_as_n    (cpu_as_n),
      .cpu_ram_sel (cpu_ram_sel),
      .cpu_rd_wr_n (cpu_rd_wr_n),
      .cpu_waddr   (cpu_waddr),
      .kind_now    (kind_now),
      .kind_q      (kind_q),
      .waddr_now   (waddr_now),
      .waddr_q     (waddr_q)
   );

   sdseq_cmd_gen #(
      .COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W),
      .SA_W(SA_W), .AP_BIT(AP_BIT), .BYTES(BYTES)
   ) i_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .kind_now  (kind_now),
      .kind_q    (kind_q),
      .waddr_now (waddr_now),
      .waddr_q   (waddr_q),
      .cpu_be_n  (cpu_be_n),
      .cmd       (cmd),
      .cke       (sd_cke),
      .ba        (sd_ba),
      .sa        (sd_addr),
      .dqm       (sd_dqm),
      .oe_n      (xcvr_oe_n),
      .to_cpu    (xcvr_to_cpu)
   );

   sdseq_vid_capture #(.DATA_W(DATA_W), .WORDS(2)) i_vcap (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .kind_q   (kind_q),
      .dq_in    (sd_dq_in),
      .vid_word (vid_word)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign slot_phase = phase;

endmodule

// File: tb/test_sdram_slot_seq.sv
module test_sdram_slot_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  slot_phase;
   logic        vid_sel = 1'b0;
   logic [22:0] vid_waddr = '0;
   logic        cpu_as_n = 1'b1;
   logic        cpu_ram_sel = 1'b1;
   logic        cpu_rd_wr_n = 1'b1;
   logic [1:0]  cpu_be_n = 2'b11;
   logic [22:0] cpu_waddr = '0;
   logic [15:0] sd_dq_in = '0;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
   logic [1:0]  sd_ba;
   logic [11:0] sd_addr;
   logic [1:0]  sd_dqm;
   logic [31:0] vid_word;
   logic        xcvr_oe_n, xcvr_to_cpu;

   always #10 clk = ~clk;

   sdram_slot_seq i_sdram_slot_seq (
      .clk(clk), .rst_n(rst_n), .slot_phase(slot_phase),
      .vid_sel(vid_sel), .vid_waddr(vid_waddr),
      .cpu_as_n(cpu_as_n), .cpu_ram_sel(cpu_ram_sel), .cpu_rd_wr_n(cpu_rd_wr_n),
      .cpu_be_n(cpu_be_n), .cpu_waddr(cpu_waddr), .sd_dq_in(sd_dq_in),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_cke(sd_cke), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
      .vid_word(vid_word), .xcvr_oe_n(xcvr_oe_n), .xcvr_to_cpu(xcvr_to_cpu)
   );

   localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100, REF = 4'b0001;
   localparam int K_IDLE = 0, K_VID = 1, K_RD = 2, K_WR = 3;
   localparam int N_SLOTS = 2500;

   int checks = 0;
   int failures = 0;
   logic run = 1'b0;
   logic done = 1'b0;
   int   slot_idx = 0;
   logic late_strobe = 1'b0;

   logic [3:0]  exp_ph = '0;
   int          b_kind = K_IDLE;
   logic [22:0] b_waddr = '0;
   logic [15:0] cap_lo = '0, cap_hi = '0;
   logic [31:0] exp_vw = '0;

   logic [3:0]  e_cmd;
   logic        e_cke, e_oe_n, e_dir;
   logic [1:0]  e_ba, e_dqm;
   logic [11:0] e_sa;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s phase=%0d slot=%0d actual=%h expected=%h", tag, exp_ph, slot_idx, act, exp);
      end
   endtask

   function automatic int live_kind();
      if (vid_sel) return K_VID;
      if (cpu_as_n || !cpu_ram_sel) return K_IDLE;
      return cpu_rd_wr_n ? K_RD : K_WR;
   endfunction

   function automatic logic [11:0] col_word(input logic [8:0] c, input logic ap);
      logic [11:0] r;
      r = '0;
      r[8:0] = c;
      r[10] = ap;
      return r;
   endfunction

   task automatic compute_exp(input logic [3:0] p);
      logic [22:0] a;
      e_cmd = NOP; e_cke = 1'b0; e_ba = '0; e_sa = '0; e_dqm = '0; e_oe_n = 1'b1; e_dir = 1'b0;
      if (p == 4) begin
         e_cke = 1'b1;
      end else if (p == 5) begin
         e_cke = 1'b1;
         if (live_kind() != K_IDLE) begin
            a = vid_sel ? vid_waddr : cpu_waddr;
            e_cmd = ACT; e_ba = a[22:21]; e_sa = a[20:9];
         end
      end else if (p >= 6 && p <= 14) begin
         case (b_kind)
            K_VID: begin
               e_cke = (p <= 12) && (p != 8) && (p != 10);
               if (p == 6) begin e_cmd = RD; e_ba = b_waddr[22:21]; e_sa = col_word({b_waddr[8:1], 1'b0}, 1'b0); end
               if (p == 7) begin e_cmd = RD; e_ba = b_waddr[22:21]; e_sa = col_word({b_waddr[8:1], 1'b1}, 1'b1); end
               if (p == 11) e_cmd = REF;
            end
            K_RD: begin
               e_cke = (p <= 12);
               e_dir = (p >= 7);
               e_oe_n = !(p >= 9);
               if (p == 7) begin e_cmd = RD; e_ba = b_waddr[22:21]; e_sa = col_word(b_waddr[8:0], 1'b1); end
            end
            K_WR: begin
               e_cke = (p <= 12);
               e_oe_n = !(p <= 8);
               if (p == 7) begin e_cmd = WR; e_ba = b_waddr[22:21]; e_sa = col_word(b_waddr[8:0], 1'b1); e_dqm = cpu_be_n; end
            end
            default: ;
         endcase
      end
   endtask

   function automatic string tag_for(input logic [3:0] p, input int k);
      if (p <= 4 || p >= 13) return "R2";
      if (p == 5) return "R3";
      case (k)
         K_VID:   return "R4";
         K_RD:    return "R6";
         K_WR:    return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic new_slot();
      int r;
      late_strobe = 1'b0;
      vid_waddr = 23'($urandom);
      cpu_waddr = 23'($urandom);
      cpu_be_n = 2'($urandom);
      cpu_ram_sel = 1'b1;
      case (slot_idx)
         0: begin vid_sel = 1'b1; cpu_as_n = 1'b1; end
         1: begin vid_sel = 1'b0; cpu_as_n = 1'b0; cpu_rd_wr_n = 1'b1; end
         2: begin vid_sel = 1'b0; cpu_as_n = 1'b0; cpu_rd_wr_n = 1'b0; cpu_be_n = 2'b10; end
         3: begin vid_sel = 1'b0; cpu_as_n = 1'b1; end
         4: begin vid_sel = 1'b0; cpu_as_n = 1'b1; late_strobe = 1'b1; end
         5: begin vid_sel = 1'b0; cpu_as_n = 1'b0; cpu_ram_sel = 1'b0; end
         6: begin vid_sel = 1'b1; vid_waddr = 23'h7FFFFF; end
         7: begin vid_sel = 1'b0; cpu_as_n = 1'b0; cpu_rd_wr_n = 1'b0; cpu_be_n = 2'b01; cpu_waddr = '0; end
         default: begin
            r = int'($urandom_range(0, 9));
            vid_sel = (r < 3);
            cpu_as_n = (r >= 3 && r < 5);
            late_strobe = (r == 5) && !vid_sel;
            if (late_strobe) cpu_as_n = 1'b1;
            cpu_ram_sel = (r != 6);
            cpu_rd_wr_n = 1'($urandom);
         end
      endcase
      slot_idx++;
   endtask

   // bench model of state carried across edges
   always @(posedge clk) begin
      if (run) begin
         if (exp_ph == 5) begin
            b_kind = live_kind();
            b_waddr = vid_sel ? vid_waddr : cpu_waddr;
         end
         if (b_kind == K_VID && exp_ph == 9) cap_lo = sd_dq_in;
         if (b_kind == K_VID && exp_ph == 11) begin
            cap_hi = sd_dq_in;
            exp_vw = {cap_hi, cap_lo};
         end
         exp_ph = exp_ph + 4'd1;
      end
   end

   always @(negedge clk) begin
      if (run && !done) begin
         check("R1 phase", 32'(slot_phase), 32'(exp_ph));
         compute_exp(exp_ph);
         check({tag_for(exp_ph, b_kind), " cmd"}, 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(e_cmd));
         check({tag_for(exp_ph, b_kind), " cke"}, 32'(sd_cke), 32'(e_cke));
         check("R9 bank", 32'(sd_ba), 32'(e_ba));
         check("R9 addr", 32'(sd_addr), 32'(e_sa));
         check("R7 dqm", 32'(sd_dqm), 32'(e_dqm));
         check("R10 oe_n", 32'(xcvr_oe_n), 32'(e_oe_n));
         check("R10 dir", 32'(xcvr_to_cpu), 32'(e_dir));
         if (exp_ph != 10 && exp_ph != 11) check("R5 vid_word", vid_word, exp_vw);
         // drive next inputs
         sd_dq_in = 16'($urandom);
         if (exp_ph == 8 && late_strobe) begin
            cpu_as_n = 1'b0;
            cpu_rd_wr_n = 1'($urandom);
         end
         if (exp_ph == 15) begin
            if (slot_idx >= N_SLOTS) done = 1'b1;
            else new_slot();
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset phase", 32'(slot_phase), 32'd0);
      check("R2 reset cke", 32'(sd_cke), 32'd0);
      check("R2 reset cmd", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(NOP));
      check("R10 reset oe_n", 32'(xcvr_oe_n), 32'd1);
      check("R5 reset vid_word", vid_word, 32'd0);
      rst_n = 1'b1;
      exp_ph = '0;
      new_slot();
      run = 1'b1;
      wait (done);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule